// File: doc/BRIEF.md
# Two-wire configuration register slave

This block is a serial slave on a two-wire bus that lets a host read and change a small file of configuration bytes, such as enables for individual clock outputs. Both bus lines are oversampled by the system clock. The block finds start and stop conditions, answers to one fixed address, and supports four transfer types: byte read, byte write, block read and block write. Each register bit also leaves the block in parallel, so it can drive the hardware directly.

Every register takes a preset value at reset, so a system that never touches the bus still gets a working setup. The command byte picks the transfer type. With its top bit set, the low seven bits select one register for a byte transfer. With the top bit clear, the transfer is a block transfer. It always begins at register 0 and moves upward one byte at a time, and each byte goes out most significant bit first.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register holds RST_BYTE (default FFh), regs_o shows these values with register k at bits 8k+7:8k, and SDA is released.
- R2: The block ACKs the address byte 1101001 followed by a read/write bit (D2h for a write, D3h for a read). Any other address gets a NACK, and SDA stays released for every later bit until the next start condition.
- R3: Byte write: a command byte with bit 7 = 1 names the offset in bits 6:0. The next data byte is stored at that offset, and the command and data bytes are both ACKed.
- R4: Byte read: a write address, a command with bit 7 = 1, a repeated start and then a read address return the register at the stored offset, MSB first. The offset survives the repeated start.
- R5: Block write: a command of 00h and then a byte-count byte (its value is not used) are followed by data bytes that go to registers 0, 1, 2 and so on. A stop after any complete byte keeps every byte written so far.
- R6: Block read: a block command, a repeated start and a read address return a count byte equal to NUM_REGS (32), then the registers from 0 upward.
- R7: A write to an offset of NUM_REGS or above is ACKed and discarded. A read from such an offset returns 00h.
- R8: When the host NACKs a read byte, the block releases SDA and drives nothing more until the next start condition.
- R9: The block changes SDA only after a falling SCL edge, or when a start or stop resets it. The value it drives is stable while SCL is high.
- R10: Register contents change only when a written data byte is accepted. Read transfers leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| regs_o | output | NUM_REGS*8 | All register bits, register k at bits 8k+7:8k |

## Verification
Each line passes through two synchronizer flops and an edge register before the control logic acts on it. The block therefore reacts about three to four system clocks after an SCL or SDA transition. The bench holds every SCL quarter phase for ten system clocks and reads ACK and data bits halfway through the SCL high time, when any response is long settled. A register write appears on regs_o a few clocks after the falling SCL edge that ends the eighth data bit, so the bench compares regs_o only after the stop condition. It checks the release of SDA one quarter phase after the falling edge that follows the host's NACK.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_CNT, PH_WDATA, PH_RDATA, PH_IGNORE
  } smb_phase_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= in_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         NUM_REGS = 32,
  parameter logic [7:0] RST_BYTE = 8'hFF,
  parameter int         OFF_W    = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [OFF_W-1:0]      waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [OFF_W-1:0]      raddr_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= RST_BYTE;
      else if (we_i && (int'(waddr_i) == g)) mem_q[g] <= wdata_i;
    end
    assign regs_o[8*g +: 8] = mem_q[g];
  end

  // out-of-range reads return zero
  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(raddr_i) == i) rdata_o = mem_q[i];
  end

  // R10
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 32,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] RST_BYTE = 8'hFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int         OFF_W = 7;
  localparam logic [7:0] CNT_B = 8'(NUM_REGS);

  logic [1:0] lvl, rise, fall;
  logic       scl_rise, scl_fall, scl_lvl, sda_s, start, stop;

  smb_sync #(.W(2)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_i ({sda_i, scl_i}),
    .lvl_o (lvl), .rise_o (rise), .fall_o (fall)
  );

  assign scl_lvl  = lvl[0];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_s    = lvl[1];
  assign start    = scl_lvl & fall[1];
  assign stop     = scl_lvl & rise[1];

  smb_phase_e       phase_q, nxt_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q, tx_q;
  logic [OFF_W-1:0] off_q;
  logic             sda_oe_q, blk_q, cnt_pend_q, mack_q;
  logic             active, we, go_rd;
  logic [7:0]       rd_data, ld_byte;

  assign active  = (phase_q != PH_IDLE) && (phase_q != PH_IGNORE);
  assign we      = active && !start && !stop && scl_fall &&
                   bit_cnt_q == 4'd8 && phase_q == PH_WDATA;
  assign go_rd   = (phase_q == PH_RDATA) ? mack_q : (nxt_q == PH_RDATA);
  assign ld_byte = cnt_pend_q ? CNT_B : rd_data;

  smb_regfile #(.NUM_REGS(NUM_REGS), .RST_BYTE(RST_BYTE), .OFF_W(OFF_W)) i_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (we), .waddr_i (off_q),
    .wdata_i (shreg_q), .raddr_i (off_q), .rdata_o (rd_data), .regs_o (regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      nxt_q      <= PH_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      off_q      <= '0;
      sda_oe_q   <= 1'b0;
      blk_q      <= 1'b0;
      cnt_pend_q <= 1'b0;
      mack_q     <= 1'b0;
    end else if (start) begin
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else if (stop) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_cnt_q < 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (bit_cnt_q == 4'd9) begin
          mack_q <= ~sda_s;
        end
      end else if (scl_fall) begin
        if (bit_cnt_q == 4'd8) begin
          // end of a byte: enter the acknowledge slot
          bit_cnt_q <= 4'd9;
          sda_oe_q  <= 1'b0;
          unique case (phase_q)
            PH_ADDR: begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                sda_oe_q <= 1'b1;
                if (shreg_q[0]) begin
                  nxt_q      <= PH_RDATA;
                  cnt_pend_q <= blk_q;
                end else begin
                  nxt_q <= PH_CMD;
                end
              end else begin
                phase_q <= PH_IGNORE;
              end
            end
            PH_CMD: begin
              sda_oe_q <= 1'b1;
              blk_q    <= ~shreg_q[7];
              off_q    <= shreg_q[7] ? shreg_q[6:0] : '0;
              nxt_q    <= shreg_q[7] ? PH_WDATA : PH_CNT;
            end
            PH_CNT: begin
              sda_oe_q <= 1'b1;
              nxt_q    <= PH_WDATA;
            end
            PH_WDATA: begin
              sda_oe_q <= 1'b1;
              off_q    <= off_q + 1'b1;
              nxt_q    <= PH_WDATA;
            end
            default: ;
          endcase
        end else if (bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
          if (go_rd) begin
            phase_q  <= PH_RDATA;
            tx_q     <= ld_byte;
            sda_oe_q <= ~ld_byte[7];
            if (cnt_pend_q) cnt_pend_q <= 1'b0;
            else            off_q      <= off_q + 1'b1;
          end else begin
            sda_oe_q <= 1'b0;
            phase_q  <= (phase_q == PH_RDATA) ? PH_IGNORE : nxt_q;
          end
        end else if (phase_q == PH_RDATA && bit_cnt_q != 4'd0) begin
          sda_oe_q <= ~tx_q[6];
          tx_q     <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe_o = sda_oe_q;

  // R2 R8
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE || phase_q == PH_IGNORE) |-> !sda_oe_o);

  // R9
  sda_only_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall && !start && !stop) |=> $stable(sda_oe_o));

  // R3
  ack_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && phase_q != PH_RDATA) |-> bit_cnt_q == 4'd9);

  // R9
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd9);
endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int NREG = 32;
  localparam int Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_line = sda_h & ~sda_oe;
  int   n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  smb_cfg_slave i_smb_cfg_slave (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl_h), .sda_i (sda_line),
    .sda_oe_o (sda_oe), .regs_o (regs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1'b1; qw(); scl_h = 1'b1; qw(); sda_h = 1'b0; qw(); scl_h = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; qw(); scl_h = 1'b1; qw(); sda_h = 1'b1; qw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qw(); scl_h = 1'b1; qw(); qw(); scl_h = 1'b0; qw();
    end
    sda_h = 1'b1; qw(); scl_h = 1'b1; qw(); ack = ~sda_line; qw(); scl_h = 1'b0; qw();
  endtask

  task automatic rd_byte(input bit host_ack, output logic [7:0] b);
    logic a, c;
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_h = 1'b1; qw(); a = sda_line; qw(); c = sda_line;
      b[i] = a; scl_h = 1'b0;
      check(a == c, "R9 stable while SCL high", c, a);
    end
    sda_h = ~host_ack; qw(); scl_h = 1'b1; qw(); qw(); scl_h = 1'b0; qw();
    sda_h = 1'b1;
  endtask

  function automatic logic [7:0] reg_at(input int k);
    return regs[8*k +: 8];
  endfunction

  task automatic t_reset();
    bit ok = 1'b1;
    for (int k = 0; k < NREG; k++) if (reg_at(k) != 8'hFF) ok = 1'b0;
    check(ok, "R1 registers preset", reg_at(0), 8'hFF);
    check(sda_oe == 1'b0, "R1 SDA released", sda_oe, 0);
  endtask

  task automatic t_byte_write();
    bit a0, a1, a2;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h85, a1); wr_byte(8'h3C, a2); bus_stop();
    check(a0, "R2 write address acked", a0, 1);
    check(a1 && a2, "R3 command and data acked", {a1, a2}, 3);
    check(reg_at(5) == 8'h3C, "R3 reg5 written", reg_at(5), 8'h3C);
    check(reg_at(4) == 8'hFF, "R3 reg4 untouched", reg_at(4), 8'hFF);
  endtask

  task automatic t_byte_read();
    bit a0, a1, a2;
    logic [7:0] d;
    logic [NREG*8-1:0] snap = regs;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h85, a1);
    bus_start(); wr_byte(8'hD3, a2);
    check(a2, "R2 read address acked", a2, 1);
    rd_byte(1'b0, d);
    check(d == 8'h3C, "R4 byte read at kept offset", d, 8'h3C);
    qw();
    check(sda_oe == 1'b0, "R8 release after host NACK", sda_oe, 0);
    bus_stop();
    check(regs == snap, "R10 read leaves registers", reg_at(5), snap[8*5 +: 8]);
  endtask

  task automatic t_bad_addr();
    bit a0, a1;
    logic [NREG*8-1:0] snap = regs;
    bus_start(); wr_byte(8'hA0, a0); wr_byte(8'h85, a1); wr_byte(8'h00, a1); bus_stop();
    check(!a0, "R2 wrong address NACK", a0, 0);
    check(!a1, "R2 silent until next start", a1, 0);
    check(regs == snap, "R10 ignored transfer writes nothing", reg_at(5), snap[8*5 +: 8]);
  endtask

  task automatic t_block_write();
    bit a, all_ok = 1'b1;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a); all_ok &= a;
    wr_byte(8'h03, a); all_ok &= a;
    wr_byte(8'h11, a); all_ok &= a; wr_byte(8'h22, a); all_ok &= a;
    wr_byte(8'h33, a); all_ok &= a; bus_stop();
    check(all_ok, "R5 block bytes acked", all_ok, 1);
    check(reg_at(0) == 8'h11 && reg_at(1) == 8'h22 && reg_at(2) == 8'h33,
          "R5 block write order", reg_at(2), 8'h33);
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h04, a);
    wr_byte(8'h44, a); bus_stop();
    check(reg_at(0) == 8'h44 && reg_at(1) == 8'h22, "R5 early stop keeps bytes",
          {reg_at(0), reg_at(1)}, 16'h4422);
  endtask

  task automatic t_block_read();
    bit a;
    logic [7:0] c, d0, d1, d2;
    logic [NREG*8-1:0] snap = regs;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a);
    bus_start(); wr_byte(8'hD3, a);
    rd_byte(1'b1, c); rd_byte(1'b1, d0); rd_byte(1'b1, d1); rd_byte(1'b0, d2);
    qw();
    check(sda_oe == 1'b0, "R8 release after last block byte", sda_oe, 0);
    bus_stop();
    check(c == 8'd32, "R6 count byte", c, 32);
    check({d0, d1, d2} == 24'h442233, "R6 block data", {d0, d1, d2}, 24'h442233);
    check(regs == snap, "R10 block read leaves registers", reg_at(0), snap[7:0]);
  endtask

  task automatic t_out_range();
    bit a0, a1;
    logic [7:0] d;
    logic [NREG*8-1:0] snap = regs;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'hD0, a0); wr_byte(8'h77, a1); bus_stop();
    check(a0 && a1, "R7 out-of-range write acked", {a0, a1}, 3);
    check(regs == snap, "R7 out-of-range write discarded", reg_at(0), snap[7:0]);
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'hD0, a0);
    bus_start(); wr_byte(8'hD3, a0); rd_byte(1'b0, d); bus_stop();
    check(d == 8'h00, "R7 out-of-range read zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_bad_addr();
    t_block_write();
    t_block_read();
    t_out_range();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule